// File: doc/BRIEF.md
# Thresholded Zero-Run Encoder

This block compresses a stream of signed wavelet coefficients. The coefficients of many channels and decomposition levels arrive interleaved on one port. Each coefficient is first tested against a magnitude threshold. A coefficient whose magnitude is below the threshold, or which is exactly zero, counts as zero and produces no output word.

Zero coefficients are counted in one counter that is shared by the whole interleaved stream. No state is kept per channel. When a significant coefficient arrives, the block first emits the accumulated zero count as a run token. It then emits the coefficient unchanged as a literal token.

Each output word carries a flag that marks it as a run or a literal. The counter never exceeds its maximum value: when it fills, a full-length run token goes out and counting begins again. A flush request emits any partial run at a frame boundary. The input side uses a valid/ready handshake, and the output side is a registered valid/ready port.

Top module: `zrle_encoder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: An accepted coefficient counts as zero, and produces no output of its own, when it is 0 or when its two's-complement magnitude is strictly less than thresh. With thresh=5, the values 4, -4 and 3 count as zero, while 5 and -5 do not. With thresh=0, only the value 0 counts as zero. The most negative value has magnitude 2^(DW-1).
- R3: An accepted significant coefficient with no pending zeros produces one literal token on the next cycle: out_run=0 and out_data equal to the coefficient.
- R4: An accepted significant coefficient with N>0 pending zeros produces a run token first (out_run=1, out_data=N in the low RUN_W bits, upper bits 0). The literal token for the coefficient follows the accepted run token, and the count restarts at 0.
- R5: in_ready is 0 while a literal is waiting behind a run token, and while an output word is held by out_ready=0.
- R6: Reaching 2^RUN_W-1 consecutive zeros (255 by default) emits a run token of that value and restarts the count. A run token is never 0.
- R7: A flush cycle emits a run token of the pending count when that count is nonzero and nothing otherwise. It clears the count, and in_ready is 0 during it.
- R8: While out_valid=1 and out_ready=0, out_valid, out_run and out_data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| thresh | input | DW | Unsigned magnitude threshold |
| in_valid | input | 1 | Coefficient present |
| in_ready | output | 1 | Coefficient taken this cycle |
| in_data | input | DW | Signed coefficient |
| flush | input | 1 | Emit the pending zero run (frame end) |
| out_valid | output | 1 | Output token present |
| out_ready | input | 1 | Consumer accepts token |
| out_run | output | 1 | 1 = run count token, 0 = literal token |
| out_data | output | DW | Run count (zero-extended) or coefficient |

## Verification
A run token and a literal token become due in the same cycle whenever a significant coefficient ends a zero run. Only one token can leave per cycle, so the literal has to wait. The bench provokes this case both with the output free and with out_ready held low across the collision. It judges the result by the order and values of the collected tokens, and by in_ready staying low while the literal waits. Flushes at a frame boundary, and saturation of the run counter, are checked the same way.

// File: rtl/zrle_encoder.sv
module zrle_encoder #(
  parameter int DW    = 16,
  parameter int RUN_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        thresh,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  input  logic                 flush,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_run,
  output logic [DW-1:0]        out_data
);
  localparam logic [RUN_W-1:0] MAX_RUN = '1;

  logic [RUN_W-1:0] cnt;
  logic             lit_pend;
  logic [DW-1:0]    lit_data;
  logic [DW-1:0]    mag;
  logic             is_zero, free, take;

  assign mag      = in_data[DW-1] ? (~in_data + 1'b1) : in_data;
  assign is_zero  = (mag < thresh) || (in_data == '0);
  assign free     = !out_valid || out_ready;
  assign in_ready = free && !lit_pend && !flush;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      lit_pend  <= 1'b0;
      lit_data  <= '0;
      out_valid <= 1'b0;
      out_run   <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (free) begin
        if (lit_pend) begin
          out_valid <= 1'b1;
          out_run   <= 1'b0;
          out_data  <= lit_data;
          lit_pend  <= 1'b0;
        end else if (flush) begin
          if (cnt != '0) begin
            out_valid <= 1'b1;
            out_run   <= 1'b1;
            out_data  <= DW'(cnt);
            cnt       <= '0;
          end
        end else if (take) begin
          if (is_zero) begin
            if (cnt == MAX_RUN - 1'b1) begin
              out_valid <= 1'b1;
              out_run   <= 1'b1;
              out_data  <= DW'(MAX_RUN);
              cnt       <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (cnt != '0) begin
            out_valid <= 1'b1;
            out_run   <= 1'b1;
            out_data  <= DW'(cnt);
            lit_pend  <= 1'b1;
            lit_data  <= in_data;
            cnt       <= '0;
          end else begin
            out_valid <= 1'b1;
            out_run   <= 1'b0;
            out_data  <= in_data;
          end
        end
      end
    end
  end

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_run) && $stable(out_data)));

  a_r5_block_pending: assert property (@(posedge clk) disable iff (!rst_n)
    lit_pend |-> !in_ready);

  a_r4_literal_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (lit_pend && free) |=> (out_valid && !out_run && !lit_pend));

  a_r6_run_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_run) |-> (out_data != '0 && out_data <= DW'(MAX_RUN)));

  a_r6_cnt_below_max: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != MAX_RUN);

  a_r3_direct_literal: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !is_zero && cnt == '0) |=> (out_valid && !out_run && out_data == $past(in_data)));
endmodule

// File: tb/zrle_encoder_bench.sv
module zrle_encoder_bench;
  localparam int DW = 16;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [DW-1:0]        thresh = 16'd5;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [DW-1:0] in_data = '0;
  logic                 flush = 1'b0;
  logic                 out_valid;
  logic                 out_ready = 1'b1;
  logic                 out_run;
  logic [DW-1:0]        out_data;

  int n_chk = 0;
  int n_bad = 0;
  int n_got = 0;
  logic          got_run [0:63];
  logic [DW-1:0] got_dat [0:63];

  always #2.5 clk = ~clk;

  zrle_encoder #(.DW(DW), .RUN_W(8)) u_zrle_encoder (
    .clk(clk), .rst_n(rst_n), .thresh(thresh), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .flush(flush),
    .out_valid(out_valid), .out_ready(out_ready), .out_run(out_run),
    .out_data(out_data)
  );

  always @(negedge clk)
    if (rst_n && out_valid && out_ready && n_got < 64) begin
      got_run[n_got] = out_run;
      got_dat[n_got] = out_data;
      n_got = n_got + 1;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tok(input int idx, input bit run, input logic [DW-1:0] dat, input string req);
    if (idx >= n_got) chk(1'b0, req, n_got, idx + 1);
    else chk(got_run[idx] == run && got_dat[idx] == dat, req,
             int'({got_run[idx], got_dat[idx]}), int'({run, dat}));
  endtask

  task automatic push(input logic signed [DW-1:0] v);
    in_valid = 1'b1;
    in_data  = v;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_flush(input string req);
    flush = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, req, in_ready, 0);
    @(posedge clk); #1;
    flush = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic t_literals;
    n_got = 0; thresh = 16'd5;
    push(16'sd7); push(-16'sd9);
    idle(3);
    chk(n_got == 2, "R3 count", n_got, 2);
    tok(0, 1'b0, 16'd7, "R3 lit 7");
    tok(1, 1'b0, -16'sd9, "R3 lit -9");
  endtask

  task automatic t_threshold;
    n_got = 0; thresh = 16'd5;
    push(16'sd4); push(-16'sd4); push(16'sd0); push(16'sd3);
    idle(2);
    chk(n_got == 0, "R2 sub-threshold silent", n_got, 0);
    push(16'sd5); push(-16'sd5);
    idle(3);
    chk(n_got == 3, "R4 count", n_got, 3);
    tok(0, 1'b1, 16'd4, "R4 run first");
    tok(1, 1'b0, 16'd5, "R4 literal after run");
    tok(2, 1'b0, -16'sd5, "R2 -5 literal");
  endtask

  task automatic t_edge_thresh;
    n_got = 0; thresh = 16'd0;
    push(16'sd0); push(16'sd1);
    thresh = 16'hFFFF;
    push(-16'sd32768);
    thresh = 16'h8000;
    push(-16'sd32768);
    idle(3);
    chk(n_got == 4, "R2 edge count", n_got, 4);
    tok(0, 1'b1, 16'd1, "R2 zero under thresh 0");
    tok(1, 1'b0, 16'd1, "R2 one under thresh 0");
    tok(2, 1'b1, 16'd1, "R2 min negative below FFFF");
    tok(3, 1'b0, 16'h8000, "R2 min negative not below 8000");
  endtask

  task automatic t_saturate;
    n_got = 0; thresh = 16'd5;
    for (int i = 0; i < 300; i++) push(16'sd0);
    push(16'sd9);
    idle(3);
    chk(n_got == 3, "R6 count", n_got, 3);
    tok(0, 1'b1, 16'd255, "R6 saturated run");
    tok(1, 1'b1, 16'd45, "R6 restart count");
    tok(2, 1'b0, 16'd9, "R6 literal");
  endtask

  task automatic t_flush;
    n_got = 0; thresh = 16'd5;
    push(16'sd0); push(16'sd2); push(-16'sd1);
    do_flush("R7 in_ready low");
    idle(2);
    chk(n_got == 1, "R7 flush count", n_got, 1);
    tok(0, 1'b1, 16'd3, "R7 flushed run");
    do_flush("R7 in_ready low empty");
    idle(2);
    chk(n_got == 1, "R7 empty flush silent", n_got, 1);
    push(16'sd6);
    idle(2);
    tok(1, 1'b0, 16'd6, "R7 count cleared");
  endtask

  task automatic t_backpressure;
    logic [DW-1:0] d0;
    n_got = 0; thresh = 16'd5;
    out_ready = 1'b0;
    push(16'sd0); push(16'sd0); push(16'sd8);
    @(negedge clk);
    chk(out_valid && out_run && out_data == 16'd2, "R4 run held",
        int'({out_valid, out_run, out_data}), int'({2'b11, 16'd2}));
    chk(in_ready == 1'b0, "R5 in_ready low", in_ready, 0);
    d0 = out_data;
    idle(3);
    @(negedge clk);
    chk(out_valid && out_run && out_data == d0, "R8 stable", int'(out_data), int'(d0));
    chk(in_ready == 1'b0, "R5 still low", in_ready, 0);
    @(posedge clk); #1;
    out_ready = 1'b1;
    idle(3);
    chk(n_got == 2, "R4 stalled count", n_got, 2);
    tok(0, 1'b1, 16'd2, "R4 stalled run");
    tok(1, 1'b0, 16'd8, "R4 stalled literal");
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    @(posedge clk); #1;
    t_literals();
    t_threshold();
    t_edge_thresh();
    t_saturate();
    t_flush();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule